// File: doc/BRIEF.md
# Core Power-Up Reset Sequencer

This block takes one processor core of a cluster from the powered-off state to running. A start strobe comes with a core index and a cluster index. The block then works through a fixed series of steps on that core's control lines:

1. It asserts the core's resets.
2. It asks the power switch to ramp and waits for the ramp-done handshake.
3. It opens the core's power gate and waits a settle time, counted in clock cycles.
4. It releases the power-on reset.
5. It releases the remaining core resets.

The resets and the other per-core lines are active-low, except the power gate and the L1 reset-disable line. Each core keeps its own set of lines. Only the selected core changes during a sequence.

Two cluster types exist. On the little cluster, the sequence also drives the L1 reset-disable line low and cycles the trace reset. On the big cluster, the sequence leaves trace and L1 reset-disable alone and releases the SIMD reset at the end. A one-cycle done pulse marks the end of a sequence. A request with an out-of-range core or cluster produces a one-cycle error pulse instead.

Top module: `pwrseq_core_up`

## Requirements
- R1: After reset, every core has power-on, core, debug, trace and SIMD resets at 0, L1 reset-disable at 1 and power gate at 1 (gated); ramp request, done and error are 0.
- R2: A start whose core index is NUM_CORES or more, or whose cluster index is NUM_CLUSTERS or more, raises err_o for exactly the one cycle after the strobe. It raises no ramp request and changes no per-core line.
- R3: One cycle after an accepted start is seen, the selected core's power-on and debug resets read 0 and the ramp request is 1. On the little cluster (cluster index other than BIG_CLUSTER), its trace reset and L1 reset-disable also read 0. On the big cluster (index BIG_CLUSTER), those two lines keep their values.
- R4: The ramp request stays at 1, and the power gate stays closed, until the ramp-done input is sampled high.
- R5: In the cycle after ramp-done is sampled high, the selected core's power gate reads 0 and the ramp request reads 0.
- R6: The selected core's power-on reset goes to 1 exactly SETTLE_CYCLES+1 cycles after its power gate reads 0.
- R7: One cycle after the power-on reset release, the core and debug resets read 1. The trace reset (little cluster) or the SIMD reset (big cluster) also reads 1, and the other of the two keeps its value. done_o is 1 for that one cycle only.
- R8: The lines of every core other than the selected one keep their values throughout a sequence.
- R9: A start strobe that arrives while a sequence is running is ignored. No second sequence follows, and the core it names is not touched.
- R10: Ramp-done pulses received while idle change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to power up a core |
| core_idx_i | input | IDX_W | Core to power up |
| cluster_i | input | CLUSTER_W | Cluster index; BIG_CLUSTER selects the big type |
| ramp_done_i | input | 1 | Power switch finished ramping |
| ramp_req_o | output | 1 | Request to ramp the power switch |
| por_n_o | output | NUM_CORES | Power-on reset per core, active-low |
| core_rst_n_o | output | NUM_CORES | Core reset per core, active-low |
| dbg_rst_n_o | output | NUM_CORES | Debug reset per core, active-low |
| trace_rst_n_o | output | NUM_CORES | Trace reset per core, active-low |
| simd_rst_n_o | output | NUM_CORES | SIMD unit reset per core, active-low |
| l1_rstdis_o | output | NUM_CORES | L1 reset-disable per core |
| pgate_o | output | NUM_CORES | Power gate per core, 1 = gated |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |
| err_o | output | 1 | One-cycle pulse for a rejected request |

## Verification
The bench sweeps every core on both cluster types, with ramp-done delays that differ by core. It then powers up already-running cores again, so that assertion steps become visible at the ports:
- A design that touched trace or L1 reset-disable on the big cluster would fail here.
- So would one that released trace instead of SIMD.

Settle time is counted edge by edge between gate open and power-on reset release, which catches an off-by-one in the counter. Out-of-range core and cluster indices, a start strobe in the middle of a sequence, and stray ramp-done pulses while idle are all driven. A design that accepted these would show changed lines, a second ramp request, or a missing error pulse.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ASSERT,
        ST_RAMP,
        ST_SETTLE,
        ST_POR_REL,
        ST_FINAL
    } seq_state_e;

    // One-cycle step strobes from the controller to the per-core lanes
    typedef struct packed {
        logic assert_rst;
        logic open_gate;
        logic rel_por;
        logic rel_final;
    } step_t;

    // Per-core control line state
    typedef struct packed {
        logic por_n;
        logic core_n;
        logic dbg_n;
        logic trace_n;
        logic simd_n;
        logic l1dis;
        logic gate;
    } lane_t;

    localparam lane_t LANE_OFF = '{por_n: 1'b0, core_n: 1'b0, dbg_n: 1'b0,
                                   trace_n: 1'b0, simd_n: 1'b0, l1dis: 1'b1,
                                   gate: 1'b1};

    function automatic logic req_ok(input int unsigned core, input int unsigned ncores,
                                    input int unsigned clus, input int unsigned nclus);
        return (core < ncores) && (clus < nclus);
    endfunction

endpackage

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
    import pwrseq_pkg::*;
#(
    parameter int IDX_W         = 3,
    parameter int CLUSTER_W     = 2,
    parameter int NUM_CORES     = 4,
    parameter int NUM_CLUSTERS  = 2,
    parameter int BIG_CLUSTER   = 1,
    parameter int SETTLE_CYCLES = 2500
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [IDX_W-1:0]     core_idx_i,
    input  logic [CLUSTER_W-1:0] cluster_i,
    input  logic                 ramp_done_i,
    output step_t                step_o,
    output logic [IDX_W-1:0]     sel_o,
    output logic                 big_o,
    output logic                 busy_o,
    output logic                 ramp_req_o,
    output logic                 done_o,
    output logic                 err_o
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);

    seq_state_e           state_q;
    logic [IDX_W-1:0]     sel_q;
    logic                 big_q;
    logic [CNT_W-1:0]     cnt_q;
    logic                 done_q;
    logic                 err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
            big_q   <= 1'b0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (req_ok(32'(core_idx_i), NUM_CORES, 32'(cluster_i), NUM_CLUSTERS)) begin
                            sel_q   <= core_idx_i;
                            big_q   <= (cluster_i == CLUSTER_W'(BIG_CLUSTER));
                            state_q <= ST_ASSERT;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                ST_ASSERT: state_q <= ST_RAMP;
                ST_RAMP: begin
                    if (ramp_done_i) begin
                        cnt_q   <= CNT_W'(SETTLE_CYCLES - 1);
                        state_q <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (cnt_q == '0) state_q <= ST_POR_REL;
                    else             cnt_q   <= cnt_q - CNT_W'(1);
                end
                ST_POR_REL: state_q <= ST_FINAL;
                ST_FINAL: begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        step_o.assert_rst = (state_q == ST_ASSERT);
        step_o.open_gate  = (state_q == ST_RAMP) && ramp_done_i;
        step_o.rel_por    = (state_q == ST_POR_REL);
        step_o.rel_final  = (state_q == ST_FINAL);
    end

    assign sel_o      = sel_q;
    assign big_o      = big_q;
    assign busy_o     = (state_q != ST_IDLE);
    assign ramp_req_o = (state_q == ST_RAMP);
    assign done_o     = done_q;
    assign err_o      = err_q;

endmodule

// File: rtl/pwrseq_lanes.sv
module pwrseq_lanes
    import pwrseq_pkg::*;
#(
    parameter int IDX_W     = 3,
    parameter int NUM_CORES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  step_t                step_i,
    input  logic [IDX_W-1:0]     sel_i,
    input  logic                 big_i,
    output logic [NUM_CORES-1:0] por_n_o,
    output logic [NUM_CORES-1:0] core_rst_n_o,
    output logic [NUM_CORES-1:0] dbg_rst_n_o,
    output logic [NUM_CORES-1:0] trace_rst_n_o,
    output logic [NUM_CORES-1:0] simd_rst_n_o,
    output logic [NUM_CORES-1:0] l1_rstdis_o,
    output logic [NUM_CORES-1:0] pgate_o
);
    lane_t lane_q [NUM_CORES];

    for (genvar k = 0; k < NUM_CORES; k++) begin : g_lane
        logic hit;
        assign hit = (sel_i == IDX_W'(k));

        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q[k] <= LANE_OFF;
            end else if (hit) begin
                if (step_i.assert_rst) begin
                    lane_q[k].por_n <= 1'b0;
                    lane_q[k].dbg_n <= 1'b0;
                    if (!big_i) begin
                        lane_q[k].trace_n <= 1'b0;
                        lane_q[k].l1dis   <= 1'b0;
                    end
                end
                if (step_i.open_gate) lane_q[k].gate  <= 1'b0;
                if (step_i.rel_por)   lane_q[k].por_n <= 1'b1;
                if (step_i.rel_final) begin
                    lane_q[k].core_n <= 1'b1;
                    lane_q[k].dbg_n  <= 1'b1;
                    if (big_i) lane_q[k].simd_n  <= 1'b1;
                    else       lane_q[k].trace_n <= 1'b1;
                end
            end
        end

        assign por_n_o[k]       = lane_q[k].por_n;
        assign core_rst_n_o[k]  = lane_q[k].core_n;
        assign dbg_rst_n_o[k]   = lane_q[k].dbg_n;
        assign trace_rst_n_o[k] = lane_q[k].trace_n;
        assign simd_rst_n_o[k]  = lane_q[k].simd_n;
        assign l1_rstdis_o[k]   = lane_q[k].l1dis;
        assign pgate_o[k]       = lane_q[k].gate;
    end

endmodule

// File: rtl/pwrseq_core_up.sv
module pwrseq_core_up
    import pwrseq_pkg::*;
#(
    parameter int IDX_W         = 3,
    parameter int CLUSTER_W     = 2,
    parameter int NUM_CORES     = 4,
    parameter int NUM_CLUSTERS  = 2,
    parameter int BIG_CLUSTER   = 1,
    parameter int SETTLE_CYCLES = 2500
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [IDX_W-1:0]     core_idx_i,
    input  logic [CLUSTER_W-1:0] cluster_i,
    input  logic                 ramp_done_i,
    output logic                 ramp_req_o,
    output logic [NUM_CORES-1:0] por_n_o,
    output logic [NUM_CORES-1:0] core_rst_n_o,
    output logic [NUM_CORES-1:0] dbg_rst_n_o,
    output logic [NUM_CORES-1:0] trace_rst_n_o,
    output logic [NUM_CORES-1:0] simd_rst_n_o,
    output logic [NUM_CORES-1:0] l1_rstdis_o,
    output logic [NUM_CORES-1:0] pgate_o,
    output logic                 done_o,
    output logic                 err_o
);
    step_t            step;
    logic [IDX_W-1:0] sel;
    logic             big;
    logic             busy;

    pwrseq_ctrl #(
        .IDX_W(IDX_W), .CLUSTER_W(CLUSTER_W), .NUM_CORES(NUM_CORES),
        .NUM_CLUSTERS(NUM_CLUSTERS), .BIG_CLUSTER(BIG_CLUSTER),
        .SETTLE_CYCLES(SETTLE_CYCLES)
    ) u_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .core_idx_i(core_idx_i),
        .cluster_i(cluster_i), .ramp_done_i(ramp_done_i), .step_o(step),
        .sel_o(sel), .big_o(big), .busy_o(busy), .ramp_req_o(ramp_req_o),
        .done_o(done_o), .err_o(err_o)
    );

    pwrseq_lanes #(.IDX_W(IDX_W), .NUM_CORES(NUM_CORES)) u_lanes (
        .clk(clk), .rst(rst), .step_i(step), .sel_i(sel), .big_i(big),
        .por_n_o(por_n_o), .core_rst_n_o(core_rst_n_o), .dbg_rst_n_o(dbg_rst_n_o),
        .trace_rst_n_o(trace_rst_n_o), .simd_rst_n_o(simd_rst_n_o),
        .l1_rstdis_o(l1_rstdis_o), .pgate_o(pgate_o)
    );

endmodule

// File: rtl/pwrseq_checker.sv
module pwrseq_checker #(
    parameter int IDX_W        = 3,
    parameter int CLUSTER_W    = 2,
    parameter int NUM_CORES    = 4,
    parameter int NUM_CLUSTERS = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 busy,
    input logic [IDX_W-1:0]     sel,
    input logic                 big,
    input logic                 start_i,
    input logic [IDX_W-1:0]     core_idx_i,
    input logic [CLUSTER_W-1:0] cluster_i,
    input logic                 ramp_req_o,
    input logic                 ramp_done_i,
    input logic                 done_o,
    input logic                 err_o,
    input logic [NUM_CORES-1:0] por_n_o,
    input logic [NUM_CORES-1:0] pgate_o,
    input logic [NUM_CORES-1:0] trace_rst_n_o,
    input logic [NUM_CORES-1:0] simd_rst_n_o,
    input logic [NUM_CORES-1:0] l1_rstdis_o
);
    // R2: bad request gives an error pulse and starts nothing
    p_reject_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && start_i && (32'(core_idx_i) >= NUM_CORES || 32'(cluster_i) >= NUM_CLUSTERS))
        |=> (err_o && !busy));

    // R4: request held until handshake
    p_ramp_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (ramp_req_o && !ramp_done_i) |=> ramp_req_o);

    // R6: no core leaves power-on reset while its gate is closed
    p_gate_before_por_r6: assert property (@(posedge clk) disable iff (rst)
        (por_n_o & pgate_o) == '0);

    // R7: done lasts one cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R7: big cluster never moves trace or L1 reset-disable
    p_big_trace_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && big) |=> ($stable(trace_rst_n_o) && $stable(l1_rstdis_o)));

    // R3: little cluster never moves SIMD reset
    p_little_simd_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && !big) |=> $stable(simd_rst_n_o));

    // R8: unselected cores untouched
    for (genvar k = 0; k < NUM_CORES; k++) begin : g_other
        p_others_r8: assert property (@(posedge clk) disable iff (rst)
            (busy && sel != IDX_W'(k)) |=>
            $stable({por_n_o[k], pgate_o[k], trace_rst_n_o[k], simd_rst_n_o[k], l1_rstdis_o[k]}));
    end

endmodule

bind pwrseq_core_up pwrseq_checker #(
    .IDX_W(IDX_W), .CLUSTER_W(CLUSTER_W), .NUM_CORES(NUM_CORES), .NUM_CLUSTERS(NUM_CLUSTERS)
) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .sel(sel), .big(big), .start_i(start_i),
    .core_idx_i(core_idx_i), .cluster_i(cluster_i), .ramp_req_o(ramp_req_o),
    .ramp_done_i(ramp_done_i), .done_o(done_o), .err_o(err_o), .por_n_o(por_n_o),
    .pgate_o(pgate_o), .trace_rst_n_o(trace_rst_n_o), .simd_rst_n_o(simd_rst_n_o),
    .l1_rstdis_o(l1_rstdis_o)
);

// File: tb/sim_pwrseq_core_up.sv
module sim_pwrseq_core_up;
    localparam int NC = 4;
    localparam int IW = 3;
    localparam int CW = 2;
    localparam int SETTLE = 12;
    localparam int BIG = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [IW-1:0] core_idx_i = '0;
    logic [CW-1:0] cluster_i = '0;
    logic ramp_done_i = 1'b0;
    logic ramp_req_o, done_o, err_o;
    logic [NC-1:0] por_n_o, core_rst_n_o, dbg_rst_n_o, trace_rst_n_o, simd_rst_n_o, l1_rstdis_o, pgate_o;

    always #4 clk = ~clk;

    pwrseq_core_up #(.IDX_W(IW), .CLUSTER_W(CW), .NUM_CORES(NC), .NUM_CLUSTERS(2),
                     .BIG_CLUSTER(BIG), .SETTLE_CYCLES(SETTLE)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .core_idx_i(core_idx_i),
        .cluster_i(cluster_i), .ramp_done_i(ramp_done_i), .ramp_req_o(ramp_req_o),
        .por_n_o(por_n_o), .core_rst_n_o(core_rst_n_o), .dbg_rst_n_o(dbg_rst_n_o),
        .trace_rst_n_o(trace_rst_n_o), .simd_rst_n_o(simd_rst_n_o),
        .l1_rstdis_o(l1_rstdis_o), .pgate_o(pgate_o), .done_o(done_o), .err_o(err_o)
    );

    int checks = 0;
    int errors = 0;
    logic [NC-1:0] e_por, e_core, e_dbg, e_tr, e_simd, e_l1, e_pg;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_lines(input string req);
        chk(req, "por_n", 32'(por_n_o), 32'(e_por));
        chk(req, "core_rst_n", 32'(core_rst_n_o), 32'(e_core));
        chk(req, "dbg_rst_n", 32'(dbg_rst_n_o), 32'(e_dbg));
        chk(req, "trace_rst_n", 32'(trace_rst_n_o), 32'(e_tr));
        chk(req, "simd_rst_n", 32'(simd_rst_n_o), 32'(e_simd));
        chk(req, "l1_rstdis", 32'(l1_rstdis_o), 32'(e_l1));
        chk(req, "pgate", 32'(pgate_o), 32'(e_pg));
    endtask

    task automatic run_seq(input int c, input int cl, input int delay, input bit intrude);
        bit big_c = (cl == BIG);
        int n;
        core_idx_i = IW'(c); cluster_i = CW'(cl); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R3", "ramp_req before assert", 32'(ramp_req_o), 0);
        @(negedge clk);
        e_por[c] = 1'b0; e_dbg[c] = 1'b0;
        if (!big_c) begin e_tr[c] = 1'b0; e_l1[c] = 1'b0; end
        check_lines("R3");
        chk("R3", "ramp_req", 32'(ramp_req_o), 1);
        for (int i = 0; i < delay; i++) begin
            if (intrude && i == 0) begin
                core_idx_i = IW'((c + 1) % NC); cluster_i = CW'(1 - cl); start_i = 1'b1;
            end
            @(negedge clk);
            start_i = 1'b0;
            chk("R4", "ramp_req held", 32'(ramp_req_o), 1);
            chk(intrude ? "R9" : "R4", "lines while ramping", 32'(pgate_o), 32'(e_pg));
        end
        ramp_done_i = 1'b1;
        @(negedge clk);
        ramp_done_i = 1'b0;
        e_pg[c] = 1'b0;
        check_lines("R5");
        chk("R5", "ramp_req dropped", 32'(ramp_req_o), 0);
        n = 0;
        while (por_n_o[c] !== 1'b1 && n < 10000) begin
            @(negedge clk);
            n++;
            if (por_n_o[c] !== 1'b1) chk("R7", "early done", 32'(done_o), 0);
        end
        chk("R6", "settle cycles", 32'(n), 32'(SETTLE + 1));
        e_por[c] = 1'b1;
        check_lines("R6");
        @(negedge clk);
        e_core[c] = 1'b1; e_dbg[c] = 1'b1;
        if (big_c) e_simd[c] = 1'b1; else e_tr[c] = 1'b1;
        check_lines("R7");
        chk("R7", "done high", 32'(done_o), 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R7", "done low after", 32'(done_o), 0);
            chk("R9", "no second ramp", 32'(ramp_req_o), 0);
        end
        check_lines(intrude ? "R9" : "R8");
    endtask

    task automatic reject(input int c, input int cl);
        core_idx_i = IW'(c); cluster_i = CW'(cl); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2", "err pulse", 32'(err_o), 1);
        chk("R2", "no ramp", 32'(ramp_req_o), 0);
        @(negedge clk);
        chk("R2", "err cleared", 32'(err_o), 0);
        chk("R2", "no ramp later", 32'(ramp_req_o), 0);
        check_lines("R2");
    endtask

    initial begin
        e_por = '0; e_core = '0; e_dbg = '0; e_tr = '0; e_simd = '0; e_l1 = '1; e_pg = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_lines("R1");
        chk("R1", "ramp_req", 32'(ramp_req_o), 0);
        chk("R1", "done", 32'(done_o), 0);
        chk("R1", "err", 32'(err_o), 0);

        // stray handshake while idle
        ramp_done_i = 1'b1;
        repeat (3) @(negedge clk);
        ramp_done_i = 1'b0;
        @(negedge clk);
        check_lines("R10");
        chk("R10", "ramp_req idle", 32'(ramp_req_o), 0);

        // out-of-range requests
        for (int c = NC; c < 8; c++) reject(c, 0);
        reject(0, 2);
        reject(3, 3);

        // big cluster first so untouched trace/L1 lines stay observable
        for (int c = 0; c < NC; c++) run_seq(c, BIG, c + 1, c == 2);
        for (int c = 0; c < NC; c++) run_seq(c, 0, (c * 3) % 5, c == 1 && ((c * 3) % 5) > 0);
        // repower running cores: assertion steps now visible
        run_seq(1, BIG, 0, 1'b0);
        run_seq(0, 0, 2, 1'b0);
        run_seq(3, 0, 2, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule